// File: doc/BRIEF.md
# Two-Level IRQ/FIQ Interrupt Controller

This block is the first level of a two-level interrupt scheme. It takes a vector of level-sensitive request lines. Each line is the combined request of one peripheral, and the peripheral keeps its own detailed status. The block sends each line to one of two processor interrupt classes, a fast class (FIQ) and a normal class (IRQ). A per-source enable register gates which requests reach the processor.

Software reads a derived pending view for each class to find the requesting peripheral. It then queries that peripheral for the exact cause. A raw view shows every synchronized request line, whatever the enables and class choices. A control bit sets how the wakeup output treats the enables while the processor is idle. When the bit is clear, any request wakes the core. When it is set, only enabled requests wake it.

A simple synchronous read/write port gives access to the registers. Register offsets are byte addresses on 32-bit word boundaries: 0x00 IRQ view, 0x04 enable, 0x08 class, 0x0C FIQ view, 0x10 raw view, 0x14 control.

Top module: `irq_fiq_router`

## Requirements
- R1: The raw view (offset 0x10) returns the synchronized state of every source line, whatever the enable and class registers hold.
- R2: Class register bit i (offset 0x08) set to 1 steers source i to the FIQ view. Set to 0, it steers source i to the IRQ view.
- R3: The IRQ view (0x00) holds the raw bits that are enabled and of IRQ class. The FIQ view (0x0C) holds the raw bits that are enabled and of FIQ class.
- R4: Enable register bit i (0x04) set to 1 lets source i into the class views. A 0 blocks it.
- R5: `irq_o` is the OR of the IRQ view. `fiq_o` is the OR of the FIQ view.
- R6: While `idle_i` is high and control bit 0 (0x14) is 0, any raw pending bit drives `wake_o` high, whatever the enables. While `idle_i` is low, `wake_o` is low.
- R7: While control bit 0 is 1, only enabled pending bits drive `wake_o`. Control bit 0 resets to 0.
- R8: Writes to offsets 0x00, 0x0C and 0x10 are ignored. They change no register and no output.
- R9: A read returns data on `reg_rdata` one cycle after `reg_rd`. Unmapped offsets read as 0. `reg_rdata` is 0 in cycles that follow no read.
- R10: A change on a source line reaches the raw view after two clock edges, and reaches `irq_o`/`fiq_o`/`wake_o` on the third. A register write reaches these outputs one edge after the write edge.
- R11: After reset, the enable and class registers are all zeros and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level-sensitive source request lines |
| idle_i | input | 1 | Processor is in idle mode |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one cycle after reg_rd |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |
| wake_o | output | 1 | Idle-mode wakeup request |

## Verification
The assertions assume that reset is held for at least one edge before any check applies. They also assume `reg_wr` and `reg_rd` are never raised in the same cycle. The time-shifted checks further require that `idle_i` comes from synchronous logic, so its sampled value one edge back is the value the wakeup flop saw. The bench drives every input on the falling clock edge and issues reads and writes strictly one at a time. It lets the synchronizer settle before it compares the register views, so every expectation follows from the two-stage plus one-stage latency alone.

// File: rtl/irq_fiq_router.sv
module irq_fiq_router #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               idle_i,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_IRQ  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_EN   = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CLS  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_FIQ  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_RAW  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(5);

  logic [NUM_SRC-1:0] sync1_q, raw_q, en_q, cls_q;
  logic               dim_q;
  logic [NUM_SRC-1:0] irq_view, fiq_view, qualified;
  logic [IDX_W-1:0]   idx;
  logic               unused_bits;

  assign idx       = reg_addr[ADDR_W-1:2];
  assign qualified = raw_q & en_q;
  assign irq_view  = qualified & ~cls_q;
  assign fiq_view  = qualified & cls_q;
  assign unused_bits = ^{reg_addr[1:0], reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      raw_q   <= '0;
    end else begin
      sync1_q <= src_i;
      raw_q   <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      cls_q <= '0;
      dim_q <= 1'b0;
    end else if (reg_wr) begin
      case (idx)
        IDX_EN:   en_q  <= reg_wdata[NUM_SRC-1:0];
        IDX_CLS:  cls_q <= reg_wdata[NUM_SRC-1:0];
        IDX_CTRL: dim_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= |irq_view;
      fiq_o  <= |fiq_view;
      wake_o <= idle_i && (dim_q ? |qualified : |raw_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !reg_rd) begin
      reg_rdata <= '0;
    end else begin
      case (idx)
        IDX_IRQ:  reg_rdata <= DATA_W'(irq_view);
        IDX_EN:   reg_rdata <= DATA_W'(en_q);
        IDX_CLS:  reg_rdata <= DATA_W'(cls_q);
        IDX_FIQ:  reg_rdata <= DATA_W'(fiq_view);
        IDX_RAW:  reg_rdata <= DATA_W'(raw_q);
        IDX_CTRL: reg_rdata <= DATA_W'(dim_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  p_blocked_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q == '0) |-> (!irq_o && !fiq_o));

  p_fiq_needs_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(|cls_q));

  p_irq_needs_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> $past(|raw_q));

  p_wake_only_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(idle_i));

  p_wake_dim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dim_q) && $past(en_q == '0)) |-> !wake_o);

  p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> (reg_rdata == '0));

  p_sync_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (raw_q == $past(sync1_q)));
endmodule

// File: tb/tb_irq_fiq_router.sv
module tb_irq_fiq_router;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic idle_i = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_o, fiq_o, wake_o;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  irq_fiq_router dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .idle_i(idle_i),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'h04, d); chk("R11 enable reset", d, 0);
    rd(5'h08, d); chk("R11 class reset", d, 0);
    rd(5'h14, d); chk("R7 control reset", d, 0);
    chk("R11 outputs reset", {irq_o, fiq_o, wake_o}, 0);
    chk("R9 rdata quiet", reg_rdata, 0);
  endtask

  task automatic t_raw_masked();
    logic [31:0] d;
    src_i = 32'h8000_0011; settle();
    rd(5'h10, d); chk("R1 raw while blocked", d, 32'h8000_0011);
    rd(5'h00, d); chk("R4 blocked irq view", d, 0);
    chk("R4 blocked outputs", {irq_o, fiq_o}, 0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(5'h08, 32'h0000_0010);
    wr(5'h04, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R5 irq out", irq_o, 1); chk("R5 fiq out", fiq_o, 1);
    rd(5'h00, d); chk("R3 irq view", d, 32'h8000_0001);
    rd(5'h0C, d); chk("R2 fiq view", d, 32'h0000_0010);
    rd(5'h10, d); chk("R1 raw unchanged", d, 32'h8000_0011);
    wr(5'h04, 32'h0000_0010);
    @(negedge clk);
    chk("R4 partial enable irq", irq_o, 0); chk("R4 partial enable fiq", fiq_o, 1);
    wr(5'h08, 32'h0);
    @(negedge clk);
    chk("R2 reclass irq", irq_o, 1); chk("R2 reclass fiq", fiq_o, 0);
  endtask

  task automatic t_latency();
    wr(5'h04, 32'h0000_0100); wr(5'h08, 32'h0);
    src_i = 32'h0; settle();
    chk("R10 idle baseline", irq_o, 0);
    src_i = 32'h0000_0100;
    @(negedge clk); chk("R10 edge1", irq_o, 0);
    @(negedge clk); chk("R10 edge2", irq_o, 0);
    @(negedge clk); chk("R10 edge3", irq_o, 1);
    src_i = 32'h0;
    repeat (3) @(negedge clk); chk("R10 release", irq_o, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    wr(5'h04, 32'h0); src_i = 32'h0000_0004; idle_i = 1'b1; settle();
    chk("R6 wake ignores enables", wake_o, 1);
    chk("R6 no interrupt", irq_o, 0);
    idle_i = 1'b0; @(negedge clk); chk("R6 not idle", wake_o, 0);
    idle_i = 1'b1; wr(5'h14, 32'h1); @(negedge clk);
    chk("R7 wake needs enable", wake_o, 0);
    rd(5'h14, d); chk("R7 control readback", d, 1);
    wr(5'h04, 32'h0000_0004); @(negedge clk);
    chk("R7 enabled wake", wake_o, 1);
    wr(5'h14, 32'h0); wr(5'h04, 32'h0); idle_i = 1'b0; src_i = '0; settle();
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(5'h04, 32'h0000_00F0); wr(5'h08, 32'h0000_0030);
    src_i = 32'h0000_0020; settle();
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h0C, 32'h0); wr(5'h10, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(5'h04, d); chk("R8 enable kept", d, 32'h0000_00F0);
    rd(5'h08, d); chk("R8 class kept", d, 32'h0000_0030);
    rd(5'h10, d); chk("R8 raw kept", d, 32'h0000_0020);
    rd(5'h0C, d); chk("R8 fiq view kept", d, 32'h0000_0020);
    chk("R8 outputs kept", {irq_o, fiq_o}, 2'b01);
    rd(5'h18, d); chk("R9 unmapped", d, 0);
    rd(5'h1C, d); chk("R9 unmapped high", d, 0);
    @(negedge clk); chk("R9 quiet after read", reg_rdata, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw_masked();
    t_route();
    t_latency();
    t_wake();
    t_readonly();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule